// File: doc/BRIEF.md
# Offset-Cancelling Measurement Sequencer

This block drives a single shared converter channel so that each reading of a battery pack comes out free of amplifier and converter offset. On a sweep request it walks through four channels: first cell, second cell, pack current and thermistor. For each channel it sets the front-end input select and the short and reference controls, then runs two conversions through a start/done handshake with an external 12-bit converter. It subtracts one code from the other and delivers a signed, channel-tagged result with a one-cycle valid strobe.

For pack current, a zero-current bias is also removed. A sweep that is requested with the capture flag set records this bias, and this is meant for the start of a charge. For the thermistor, the divider is converted twice, once driven from the high reference and once from analog ground, and the result is the difference. A converter that never answers is caught by a time-out whose length is set at a port.

Alongside the sweep, the block keeps a small bank of voltage threshold codes. A single calibration reading of a precision 4.2 V source rescales every threshold with one sequential multiply-divide pass. A busy flag stays high until the last threshold has been written.

Top module: `meas_seq`

## Requirements
- R1: A sweep produces exactly four results in the order cell 1, cell 2, current, temperature, tagged by `res_chan` values 0, 1, 2, 3. `sweep_done` pulses in the same cycle as the temperature result. Each conversion is requested by a one-cycle `adc_start` pulse, and `fe_sel` carries the channel code during both of its conversions.
- R2: For channels 0 to 2, the first conversion runs with `fe_short`=1 and the second with `fe_short`=0. The cell result is the second code minus the first, with codes read as 12-bit two's complement.
- R3: For channel 3, the first conversion runs with `fe_ref_hi`=1 and the second with `fe_ref_hi`=0. The result is the first code minus the second. `fe_short` is never high on channel 3.
- R4: In a sweep started with `capture_req`=1, the offset-corrected current difference is stored as the bias and the current result is 0. In later sweeps, the current result is the offset-corrected difference minus the stored bias. The bias resets to 0.
- R5: Results are signed 13-bit values. A current result beyond the range saturates to +4095 or -4096.
- R6: If `adc_done` has not arrived after `tmo_cycles` cycles of waiting, `conv_err` pulses once, the sweep is abandoned with no further results and no `sweep_done`, and the block returns to idle.
- R7: A `sweep_start` received while a sweep is in progress is ignored: no extra results and no extra `sweep_done`.
- R8: A `cal_start` loads `cal_code` as the measured 4.2 V code. Each threshold i in `thr_out[i*12 +: 12]` becomes floor(old × cal_code / N42_NOM), clamped to 4095.
- R9: `cal_busy` rises the cycle after an accepted `cal_start` and falls after the last threshold is written. A `cal_start` while busy is ignored. Thresholds never change while not busy.
- R10: After reset, `adc_start`, `res_valid`, `sweep_done`, `conv_err`, `cal_busy`, `fe_short` and `fe_ref_hi` are 0, `fe_sel` is 0, and `thr_out` equals `THR_INIT`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sweep_start | input | 1 | Begin a four-channel sweep when idle |
| capture_req | input | 1 | With sweep_start: record the current bias in this sweep |
| tmo_cycles | input | TW | Wait cycles allowed per conversion (at least 1) |
| adc_start | output | 1 | One-cycle conversion request |
| adc_done | input | 1 | Conversion complete, code valid |
| adc_code | input | CW | Converter code, two's complement |
| fe_sel | output | 2 | Front-end channel select |
| fe_short | output | 1 | Short the amplifier inputs |
| fe_ref_hi | output | 1 | Drive the thermistor divider from the high reference |
| res_valid | output | 1 | Result strobe |
| res_chan | output | 2 | Channel of the result |
| res_data | output | CW+1 | Signed offset-free result |
| sweep_done | output | 1 | Sweep finished |
| conv_err | output | 1 | Converter time-out, sweep abandoned |
| cal_start | input | 1 | Start threshold rescaling |
| cal_code | input | CW | Measured 4.2 V calibration code |
| cal_busy | output | 1 | Rescaling in progress |
| thr_out | output | NTH*CW | Threshold codes, threshold i at bits i*CW |

## Verification
The bench builds the block with its defaults: 12-bit codes, four thresholds, a nominal 4.2 V code of 1654 and a 16-bit time-out counter. The time-out is a port, so a limit of 8 cycles against a silent converter triggers the error path within a few cycles, while a limit of 20 lets the three-cycle converter model answer normally. The chosen codes reach the full-scale corners: a temperature difference of +4095 and -4095, and current differences of ±4095 against an opposite bias of ±4095, which drives both saturation limits. A calibration code of 4095 pushes the rescaled thresholds past the 12-bit ceiling.

// File: rtl/meas_pkg.sv
// Shared definitions for the measurement sequencer.
// Assumes channel codes are decoded by the external front end as listed.
package meas_pkg;
    localparam logic [1:0] CH_CELL1 = 2'd0;
    localparam logic [1:0] CH_CELL2 = 2'd1;
    localparam logic [1:0] CH_CURR  = 2'd2;
    localparam logic [1:0] CH_TEMP  = 2'd3;

    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_REQ  = 2'd1,
        S_WAIT = 2'd2
    } seq_state_e;
endpackage

// File: rtl/meas_ctrl.sv
// Sweep controller: steps channels 0..3, two conversions each, drives the
// front-end controls and converter handshake, and watches for time-out.
// Assumes adc_done is only meaningful while waiting and tmo_cycles >= 1.
module meas_ctrl
    import meas_pkg::*;
#(
    parameter int TW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sweep_start,
    input  logic          capture_req,
    input  logic [TW-1:0] tmo_cycles,
    input  logic          adc_done,
    output logic          adc_start,
    output logic [1:0]    fe_sel,
    output logic          fe_short,
    output logic          fe_ref_hi,
    output logic          cv_valid,
    output logic [1:0]    cv_chan,
    output logic          cv_phase,
    output logic          capture,
    output logic          sweep_done,
    output logic          conv_err
);
    seq_state_e    st;
    logic [1:0]    ch;
    logic          ph;
    logic [TW-1:0] cnt;
    logic          cap_q;

    // Front-end controls and handshake decoded from the sequence state.
    always_comb begin
        adc_start = (st == S_REQ);
        fe_sel    = (st == S_IDLE) ? CH_CELL1 : ch;
        fe_short  = (st != S_IDLE) && !ph && (ch != CH_TEMP);
        fe_ref_hi = (st != S_IDLE) && !ph && (ch == CH_TEMP);
        cv_valid  = (st == S_WAIT) && adc_done;
        cv_chan   = ch;
        cv_phase  = ph;
        capture   = cap_q;
    end

    // Sequence state, channel/phase stepping and time-out counting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st         <= S_IDLE;
            ch         <= CH_CELL1;
            ph         <= 1'b0;
            cnt        <= '0;
            cap_q      <= 1'b0;
            sweep_done <= 1'b0;
            conv_err   <= 1'b0;
        end else begin
            sweep_done <= 1'b0;
            conv_err   <= 1'b0;
            case (st)
                S_IDLE: begin
                    if (sweep_start) begin
                        st    <= S_REQ;
                        ch    <= CH_CELL1;
                        ph    <= 1'b0;
                        cap_q <= capture_req;
                    end
                end
                S_REQ: begin
                    st  <= S_WAIT;
                    cnt <= '0;
                end
                S_WAIT: begin
                    if (adc_done) begin
                        if (!ph) begin
                            ph <= 1'b1;
                            st <= S_REQ;
                        end else if (ch == CH_TEMP) begin
                            st         <= S_IDLE;
                            ch         <= CH_CELL1;
                            ph         <= 1'b0;
                            sweep_done <= 1'b1;
                        end else begin
                            ch <= ch + 2'd1;
                            ph <= 1'b0;
                            st <= S_REQ;
                        end
                    end else if (cnt == tmo_cycles - TW'(1)) begin
                        st       <= S_IDLE;
                        ch       <= CH_CELL1;
                        ph       <= 1'b0;
                        conv_err <= 1'b1;
                    end else begin
                        cnt <= cnt + TW'(1);
                    end
                end
                default: st <= S_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/meas_diff.sv
// Difference unit: keeps the first code of a pair, forms the two-conversion
// difference, removes the stored current bias and saturates to CW+1 bits.
// Assumes cv_valid comes in phase pairs for one channel at a time.
module meas_diff
    import meas_pkg::*;
#(
    parameter int CW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cv_valid,
    input  logic [1:0]    cv_chan,
    input  logic          cv_phase,
    input  logic [CW-1:0] cv_code,
    input  logic          capture,
    output logic          res_valid,
    output logic [1:0]    res_chan,
    output logic [CW:0]   res_data
);
    localparam int DW = CW + 1;
    localparam logic [DW-1:0] MAXV = {1'b0, {CW{1'b1}}};
    localparam logic [DW-1:0] MINV = {1'b1, {CW{1'b0}}};

    logic [CW-1:0] first_q;
    logic [DW-1:0] bias_q;
    logic [DW-1:0] a_ext, b_ext, d, b_use, sat_v;
    logic [DW:0]   sub;

    // Pair difference, bias selection and saturation.
    always_comb begin
        a_ext = {cv_code[CW-1], cv_code};
        b_ext = {first_q[CW-1], first_q};
        d     = (cv_chan == CH_TEMP) ? (b_ext - a_ext) : (a_ext - b_ext);
        b_use = (cv_chan == CH_CURR) ? (capture ? d : bias_q) : '0;
        sub   = {d[DW-1], d} - {b_use[DW-1], b_use};
        if (sub[DW] != sub[DW-1])
            sat_v = sub[DW] ? MINV : MAXV;
        else
            sat_v = sub[DW-1:0];
    end

    // First-code hold, bias capture and result register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            first_q   <= '0;
            bias_q    <= '0;
            res_valid <= 1'b0;
            res_chan  <= CH_CELL1;
            res_data  <= '0;
        end else begin
            res_valid <= 1'b0;
            if (cv_valid) begin
                if (!cv_phase) begin
                    first_q <= cv_code;
                end else begin
                    res_valid <= 1'b1;
                    res_chan  <= cv_chan;
                    res_data  <= sat_v;
                    if (cv_chan == CH_CURR && capture)
                        bias_q <= d;
                end
            end
        end
    end
endmodule

// File: rtl/thr_cal.sv
// Threshold bank with sequential rescaling: each threshold is multiplied by
// the measured calibration code and divided bit-serially by the nominal code.
// Assumes NOM is nonzero and below 2**CW.
module thr_cal #(
    parameter int              CW       = 12,
    parameter int              NTH      = 4,
    parameter logic [CW-1:0]   NOM      = 12'd1654,
    parameter logic [NTH*CW-1:0] THR_INIT = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cal_start,
    input  logic [CW-1:0]     cal_code,
    output logic              cal_busy,
    output logic [NTH*CW-1:0] thr_out
);
    localparam int PW   = 2 * CW;
    localparam int IW   = (NTH > 1) ? $clog2(NTH) : 1;
    localparam int ITW  = $clog2(PW);

    logic [CW-1:0]  thr [NTH];
    logic [CW-1:0]  meas;
    logic [IW-1:0]  idx;
    logic [ITW-1:0] it;
    logic           load;
    logic [PW-1:0]  num;
    logic [PW-2:0]  quo;
    logic [CW-1:0]  rem;
    logic [CW:0]    rem_sh, rem_diff;
    logic           qbit;
    logic [PW-1:0]  q_final;
    logic [CW-1:0]  q_sat;

    // One restoring-division step and the clamped quotient.
    always_comb begin
        rem_sh   = {rem, num[PW-1]};
        rem_diff = rem_sh - {1'b0, NOM};
        qbit     = !rem_diff[CW];
        q_final  = {quo, qbit};
        q_sat    = (|q_final[PW-1:CW]) ? {CW{1'b1}} : q_final[CW-1:0];
    end

    // Calibration sequencing: load product, iterate, write back, next index.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NTH; i++) thr[i] <= THR_INIT[i*CW +: CW];
            cal_busy <= 1'b0;
            meas     <= '0;
            idx      <= '0;
            it       <= '0;
            load     <= 1'b0;
            num      <= '0;
            quo      <= '0;
            rem      <= '0;
        end else if (!cal_busy) begin
            if (cal_start) begin
                cal_busy <= 1'b1;
                meas     <= cal_code;
                idx      <= '0;
                load     <= 1'b1;
            end
        end else if (load) begin
            num  <= PW'(thr[idx]) * PW'(meas);
            quo  <= '0;
            rem  <= '0;
            it   <= '0;
            load <= 1'b0;
        end else begin
            rem <= qbit ? rem_diff[CW-1:0] : rem_sh[CW-1:0];
            quo <= q_final[PW-2:0];
            num <= {num[PW-2:0], 1'b0};
            it  <= it + ITW'(1);
            if (it == ITW'(PW - 1)) begin
                thr[idx] <= q_sat;
                if (idx == IW'(NTH - 1)) begin
                    cal_busy <= 1'b0;
                end else begin
                    idx  <= idx + IW'(1);
                    load <= 1'b1;
                end
            end
        end
    end

    for (genvar g = 0; g < NTH; g++) begin : g_out
        assign thr_out[g*CW +: CW] = thr[g];
    end
endmodule

// File: rtl/meas_seq.sv
// Top of the offset-cancelling measurement sequencer: controller, difference
// unit and calibrated threshold bank. Assumes a single external converter.
module meas_seq #(
    parameter int                CW       = 12,
    parameter int                NTH      = 4,
    parameter int                TW       = 16,
    parameter logic [CW-1:0]     N42_NOM  = 12'd1654,
    parameter logic [NTH*CW-1:0] THR_INIT = {12'd1181, 12'd1496, 12'd1614, 12'd1654}
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sweep_start,
    input  logic              capture_req,
    input  logic [TW-1:0]     tmo_cycles,
    output logic              adc_start,
    input  logic              adc_done,
    input  logic [CW-1:0]     adc_code,
    output logic [1:0]        fe_sel,
    output logic              fe_short,
    output logic              fe_ref_hi,
    output logic              res_valid,
    output logic [1:0]        res_chan,
    output logic [CW:0]       res_data,
    output logic              sweep_done,
    output logic              conv_err,
    input  logic              cal_start,
    input  logic [CW-1:0]     cal_code,
    output logic              cal_busy,
    output logic [NTH*CW-1:0] thr_out
);
    logic       cv_valid;
    logic [1:0] cv_chan;
    logic       cv_phase;
    logic       capture;

    meas_ctrl #(.TW(TW)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .sweep_start(sweep_start),
        .capture_req(capture_req), .tmo_cycles(tmo_cycles),
        .adc_done(adc_done), .adc_start(adc_start), .fe_sel(fe_sel),
        .fe_short(fe_short), .fe_ref_hi(fe_ref_hi), .cv_valid(cv_valid),
        .cv_chan(cv_chan), .cv_phase(cv_phase), .capture(capture),
        .sweep_done(sweep_done), .conv_err(conv_err)
    );

    meas_diff #(.CW(CW)) u_diff (
        .clk(clk), .rst_n(rst_n), .cv_valid(cv_valid), .cv_chan(cv_chan),
        .cv_phase(cv_phase), .cv_code(adc_code), .capture(capture),
        .res_valid(res_valid), .res_chan(res_chan), .res_data(res_data)
    );

    thr_cal #(.CW(CW), .NTH(NTH), .NOM(N42_NOM), .THR_INIT(THR_INIT)) u_cal (
        .clk(clk), .rst_n(rst_n), .cal_start(cal_start), .cal_code(cal_code),
        .cal_busy(cal_busy), .thr_out(thr_out)
    );
endmodule

// File: rtl/meas_seq_chk.sv
// Property checker for meas_seq, attached by bind.
module meas_seq_chk #(
    parameter int CW  = 12,
    parameter int NTH = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              adc_start,
    input logic [1:0]        fe_sel,
    input logic              fe_short,
    input logic              fe_ref_hi,
    input logic              res_valid,
    input logic [1:0]        res_chan,
    input logic              sweep_done,
    input logic              conv_err,
    input logic              cal_busy,
    input logic [NTH*CW-1:0] thr_out
);
    AST_START_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        adc_start |=> !adc_start); // R1
    AST_SEL_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        adc_start |=> ($stable(fe_sel) && $stable(fe_short) && $stable(fe_ref_hi))); // R2
    AST_SHORT_NOT_TEMP: assert property (@(posedge clk) disable iff (!rst_n)
        fe_short |-> (fe_sel != 2'd3) && !fe_ref_hi); // R3
    AST_REFHI_ON_TEMP: assert property (@(posedge clk) disable iff (!rst_n)
        fe_ref_hi |-> (fe_sel == 2'd3)); // R3
    AST_DONE_WITH_TEMP: assert property (@(posedge clk) disable iff (!rst_n)
        sweep_done |-> (res_valid && res_chan == 2'd3)); // R1
    AST_ERR_ALONE: assert property (@(posedge clk) disable iff (!rst_n)
        conv_err |-> (!sweep_done && !res_valid)); // R6
    AST_THR_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        !cal_busy |=> $stable(thr_out)); // R9
endmodule

bind meas_seq meas_seq_chk #(.CW(CW), .NTH(NTH)) u_chk (
    .clk(clk), .rst_n(rst_n), .adc_start(adc_start), .fe_sel(fe_sel),
    .fe_short(fe_short), .fe_ref_hi(fe_ref_hi), .res_valid(res_valid),
    .res_chan(res_chan), .sweep_done(sweep_done), .conv_err(conv_err),
    .cal_busy(cal_busy), .thr_out(thr_out)
);

// File: tb/tb_meas_seq.sv
`timescale 1ns/1ps
module tb_meas_seq;
    localparam int CW = 12, NTH = 4, TW = 16, NOM = 1654;

    logic clk = 1'b0, rst_n = 1'b0;
    logic sweep_start = 1'b0, capture_req = 1'b0;
    logic [TW-1:0] tmo_cycles = 16'd20;
    logic adc_start, adc_done, fe_short, fe_ref_hi;
    logic [CW-1:0] adc_code;
    logic [1:0] fe_sel, res_chan;
    logic res_valid, sweep_done, conv_err, cal_busy;
    logic [CW:0] res_data;
    logic cal_start = 1'b0;
    logic [CW-1:0] cal_code = '0;
    logic [NTH*CW-1:0] thr_out;

    meas_seq dut (
        .clk(clk), .rst_n(rst_n), .sweep_start(sweep_start), .capture_req(capture_req),
        .tmo_cycles(tmo_cycles), .adc_start(adc_start), .adc_done(adc_done),
        .adc_code(adc_code), .fe_sel(fe_sel), .fe_short(fe_short), .fe_ref_hi(fe_ref_hi),
        .res_valid(res_valid), .res_chan(res_chan), .res_data(res_data),
        .sweep_done(sweep_done), .conv_err(conv_err), .cal_start(cal_start),
        .cal_code(cal_code), .cal_busy(cal_busy), .thr_out(thr_out)
    );

    always #4 clk = ~clk;

    int n_checks = 0, n_errors = 0;
    int n_done = 0, n_err = 0;
    int exp_ch[$], exp_val[$];
    string exp_tag[$];
    int m_off, m_sig[3], m_thi, m_tag;
    bit m_mute = 1'b0;
    int exp_bias = 0;
    int exp_thr[NTH];
    bit finished = 1'b0;

    task automatic chk(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int sat13(input int v);
        if (v > 4095) return 4095;
        if (v < -4096) return -4096;
        return v;
    endfunction

    // Converter model: answers each start pulse three cycles later.
    initial begin
        adc_done = 1'b0;
        adc_code = '0;
        forever begin
            @(negedge clk);
            adc_done = 1'b0;
            if (adc_start && !m_mute) begin
                int v;
                if (fe_short) v = m_off;
                else if (fe_ref_hi) v = m_thi;
                else if (fe_sel == 2'd3) v = m_tag;
                else v = m_sig[fe_sel];
                repeat (2) @(negedge clk);
                adc_done = 1'b1;
                adc_code = v[CW-1:0];
            end
        end
    end

    // Monitor: pops expected results and compares them as they appear.
    initial begin
        forever begin
            @(negedge clk);
            if (sweep_done) n_done++;
            if (conv_err) n_err++;
            if (res_valid) begin
                if (exp_ch.size() == 0) begin
                    n_checks++; n_errors++;
                    $display("FAIL R7 unexpected result actual chan %0d expected none", res_chan);
                end else begin
                    int ec, ev;
                    string et;
                    ec = exp_ch.pop_front();
                    ev = exp_val.pop_front();
                    et = exp_tag.pop_front();
                    chk({"R1 channel order ", et}, int'(res_chan), ec);
                    chk({"result ", et}, int'($signed(res_data)), ev);
                end
            end
        end
    end

    // Driver: sets the converter codes, queues expected results, runs a sweep.
    task automatic do_sweep(input int off, input int s0, input int s1, input int s2,
                            input int thi, input int tg, input bit cap, input bit poke);
        int d0, d1;
        d0 = n_done;
        d1 = n_err;
        m_off = off; m_sig[0] = s0; m_sig[1] = s1; m_sig[2] = s2;
        m_thi = thi; m_tag = tg;
        exp_ch.push_back(0); exp_val.push_back(s0 - off); exp_tag.push_back("R2 cell1");
        exp_ch.push_back(1); exp_val.push_back(s1 - off); exp_tag.push_back("R2 cell2");
        if (cap) begin
            exp_bias = s2 - off;
            exp_ch.push_back(2); exp_val.push_back(0); exp_tag.push_back("R4 capture");
        end else begin
            exp_ch.push_back(2); exp_val.push_back(sat13((s2 - off) - exp_bias));
            exp_tag.push_back("R4 R5 current");
        end
        exp_ch.push_back(3); exp_val.push_back(thi - tg); exp_tag.push_back("R3 temp");
        @(negedge clk);
        sweep_start = 1'b1; capture_req = cap;
        @(negedge clk);
        sweep_start = 1'b0; capture_req = 1'b0;
        if (poke) begin
            repeat (6) @(negedge clk);
            sweep_start = 1'b1;
            @(negedge clk);
            sweep_start = 1'b0;
        end
        while (n_done == d0 && n_err == d1) @(negedge clk);
        repeat (12) @(negedge clk);
        chk("R1 all results delivered", exp_ch.size(), 0);
        chk("R1 R7 one sweep_done", n_done - d0, 1);
        chk("R7 idle after sweep", int'(adc_start), 0);
    endtask

    task automatic do_cal(input int code, input bit poke);
        for (int i = 0; i < NTH; i++) begin
            int v;
            v = (exp_thr[i] * code) / NOM;
            exp_thr[i] = (v > 4095) ? 4095 : v;
        end
        @(negedge clk);
        cal_start = 1'b1; cal_code = code[CW-1:0];
        @(negedge clk);
        cal_start = 1'b0;
        chk("R9 busy after start", int'(cal_busy), 1);
        if (poke) begin
            repeat (10) @(negedge clk);
            cal_start = 1'b1; cal_code = 12'd100;
            @(negedge clk);
            cal_start = 1'b0;
        end
        while (cal_busy) @(negedge clk);
        for (int i = 0; i < NTH; i++)
            chk("R8 R9 rescaled threshold", int'(thr_out[i*CW +: CW]), exp_thr[i]);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++; n_errors++;
        $display("FAIL watchdog actual hung expected finish");
        finish_run();
    end

    initial begin
        exp_thr[0] = 1654; exp_thr[1] = 1614; exp_thr[2] = 1496; exp_thr[3] = 1181;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        chk("R10 adc_start", int'(adc_start), 0);
        chk("R10 res_valid", int'(res_valid), 0);
        chk("R10 fe controls", int'({fe_sel, fe_short, fe_ref_hi}), 0);
        chk("R10 cal_busy", int'(cal_busy), 0);
        for (int i = 0; i < NTH; i++)
            chk("R10 threshold init", int'(thr_out[i*CW +: CW]), exp_thr[i]);

        do_sweep(5, 1000, 1200, 30, 1800, 600, 1'b1, 1'b0);
        do_sweep(-7, 1500, 1400, 300, 2047, -2048, 1'b0, 1'b0);
        do_sweep(100, -2048, 50, 0, -2048, 2047, 1'b0, 1'b0);
        // R5 positive saturation: bias -4095 then difference +4095
        do_sweep(2047, 2047, 0, -2048, 10, 10, 1'b1, 1'b0);
        do_sweep(-2048, 0, -1, 2047, 0, 5, 1'b0, 1'b1);   // R7 start mid-sweep
        // R5 negative saturation: bias +4095 then difference -4095
        do_sweep(-2048, 3, 4, 2047, 7, 1, 1'b1, 1'b0);
        do_sweep(2047, 2000, 1999, -2048, 1, 7, 1'b0, 1'b0);

        // R6 time-out with a silent converter
        begin
            int e0, d0;
            e0 = n_err; d0 = n_done;
            tmo_cycles = 16'd8;
            m_mute = 1'b1;
            @(negedge clk);
            sweep_start = 1'b1;
            @(negedge clk);
            sweep_start = 1'b0;
            repeat (30) @(negedge clk);
            chk("R6 conv_err pulses", n_err - e0, 1);
            chk("R6 no sweep_done", n_done - d0, 0);
            chk("R6 returns idle", int'({fe_sel, fe_short, adc_start}), 0);
            m_mute = 1'b0;
            tmo_cycles = 16'd20;
        end
        do_sweep(10, 20, 30, 40, 50, 60, 1'b0, 1'b0);

        do_cal(1700, 1'b1);   // R9 second start while busy ignored
        do_cal(4095, 1'b0);   // R8 clamps to 4095
        finish_run();
    end
endmodule